// File: doc/BRIEF.md
# Keyboard link command sender

This block is the host half of a two-wire keyboard link on which the device generates the clock. A host register interface presents one command byte together with a one-cycle send strobe. The block then clamps the clock line low long enough to stop the device. It asserts a start condition on the data line and hands control of the clock to the device. On each falling clock edge from the device it moves the next bit onto the data line. When the frame is over it checks the device's acknowledge and clamps the clock again so the device can act on the command.

Both lines are open-drain. The block never drives a line high: it only turns on a pull-down through an output enable. It reads both lines back through two-flop synchronizers. If the device is partway through a frame of its own when a send is requested, the block waits for that frame to end before it clamps the clock. A device clock phase that lasts longer than a configurable number of cycles ends the transfer with an error.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After a cycle with synchronous reset (`rst_n` low), both output enables, `busy_o`, `done_o` and `err_o` are low. A reset taken in the middle of a transfer releases both lines at once.
- R2: A strobe accepted while idle with no device frame in progress raises `busy_o` in the next cycle. The clock enable is then held high for exactly `INHIBIT_CYCLES` cycles with the data enable low. In the cycle the clock enable drops, the data enable rises; this is the start bit.
- R3: A frame from the device is in progress when at least one falling clock edge has been seen, fewer than 11 have been seen, and the clock has not been quiet for `TIMEOUT_CYCLES`. A strobe accepted during such a frame keeps the clock enable low until the 11th falling edge has passed and the clock has returned high. Only then does the inhibit of R2 begin.
- R4: The data line changes only in the low phase of the device clock, shortly after a falling edge. After the k-th falling edge (k = 1..8) the line carries data bit k-1, so the least significant bit goes first. A data enable of 1 means the line reads 0.
- R5: After the 9th falling edge the line carries an odd parity bit, so the nine bits together hold an odd number of ones. Command EDh gives data bits 1,0,1,1,0,1,1,1 and then parity 1.
- R6: After the 10th falling edge the data enable is low, so the stop bit reads 1.
- R7: The synchronized data line is sampled at the 11th falling edge. If it reads low (acknowledge), `done_o` pulses for one cycle, in the same cycle the clock enable rises. If it reads high, `err_o` pulses for one cycle and both enables go low.
- R8: After an acknowledge, the clock enable stays high for `HOLD_CYCLES` cycles and is then released.
- R9: During a transfer, if the synchronized clock does not change for `TIMEOUT_CYCLES` cycles, `err_o` pulses and both lines are released. This applies both while waiting for the first device edge and between edges.
- R10: `busy_o` is high from the cycle after an accepted strobe until the cycle in which `done_o` or `err_o` pulses. A strobe that arrives while `busy_o` is high is ignored, and the byte being sent does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| send_i | input | 1 | One-cycle request to send `cmd_i` |
| cmd_i | input | 8 | Command byte, captured with the strobe |
| kbd_clk_i | input | 1 | Level of the clock line (asynchronous) |
| kbd_data_i | input | 1 | Level of the data line (asynchronous) |
| kbd_clk_oe_o | output | 1 | 1 pulls the clock line low |
| kbd_data_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | A transfer is pending or running |
| done_o | output | 1 | One-cycle pulse: command acknowledged |
| err_o | output | 1 | One-cycle pulse: no acknowledge, or clock timeout |

## Verification
The bench builds the block with `INHIBIT_CYCLES` = 40, `TIMEOUT_CYCLES` = 120 and `HOLD_CYCLES` = 30. A modelled device uses clock phases of 20 cycles. These values bring a full frame, the exact inhibit length, the post-acknowledge hold and a clock-stall timeout within a few hundred cycles each. Because the device phases sit well below the timeout, a frame from the device is seen as in progress across its gaps, which makes the deferral window reachable. A stall of 120 cycles is long enough to trip the error path.

// File: rtl/ps2tx_pkg.sv
// Shared types for the keyboard link command sender.
// Assumes: the frame carries 8 data bits, odd parity and one stop bit.
package ps2tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_INHIBIT,
        ST_XFER,
        ST_HOLD
    } tx_state_t;

    // Returns the bit that makes the total count of ones odd.
    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/ps2tx_sync.sv
// Two-flop synchronizers, one per asynchronous line.
// Assumes: the lines idle high, so every stage resets to 1.
module ps2tx_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [1:0] stg;

        // Shifts the raw line level through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= 2'b11;
            else        stg <= {stg[0], din[g]};
        end

        assign dout[g] = stg[1];
    end

endmodule

// File: rtl/ps2tx_phase_timer.sv
// Finds falling edges of the synchronized clock and measures how long the
// current clock phase has lasted. The expiry flag rises once the phase
// reaches TIMEOUT_CYCLES.
// Assumes: line_i is already synchronized; restart_i clears the count.
module ps2tx_phase_timer #(
    parameter int TIMEOUT_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic restart_i,
    output logic fall_o,
    output logic expired_o
);

    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

    logic          prev_q;
    logic [CW-1:0] cnt_q;

    // Keeps the previous level and counts cycles since the last change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            prev_q <= line_i;
            if (restart_i || (line_i != prev_q))
                cnt_q <= '0;
            else if (cnt_q != CW'(TIMEOUT_CYCLES))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fall_o    = prev_q & ~line_i;
    assign expired_o = (cnt_q == CW'(TIMEOUT_CYCLES));

    // R9: the phase count saturates and never passes the timeout.
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TIMEOUT_CYCLES));

endmodule

// File: rtl/ps2tx_frame_monitor.sv
// Tracks a frame sent by the device while the host is not transmitting.
// The frame is taken as active from the first falling edge until the last
// one, or until the clock has stayed quiet for the timeout.
// Assumes: enable_i is low whenever the host itself owns the link.
module ps2tx_frame_monitor #(
    parameter int FRAME_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic fall_i,
    input  logic quiet_i,
    output logic active_o
);

    localparam int FW = $clog2(FRAME_BITS + 1);

    logic [FW-1:0] cnt_q;

    // Counts device falling edges and wraps to zero when a frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i)
            cnt_q <= '0;
        else if (fall_i)
            cnt_q <= (cnt_q == FW'(FRAME_BITS - 1)) ? '0 : cnt_q + 1'b1;
        else if (quiet_i)
            cnt_q <= '0;
    end

    assign active_o = (cnt_q != '0);

    // R3: the edge count stays inside one frame.
    a_r3_frame_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < FW'(FRAME_BITS));

endmodule

// File: rtl/ps2_cmd_tx.sv
// Host-side command sender for a two-wire keyboard link on which the device
// clocks. It clamps the clock, asserts the start bit, and moves the data bits,
// odd parity and stop bit out on device falling edges. It then checks the
// acknowledge and clamps the clock again.
// Assumes: the lines are open-drain and driven only through the *_oe_o
// outputs. The line inputs are asynchronous.
module ps2_cmd_tx
    import ps2tx_pkg::*;
#(
    parameter int INHIBIT_CYCLES = 3000,
    parameter int TIMEOUT_CYCLES = 5000,
    parameter int HOLD_CYCLES    = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       send_i,
    input  logic [7:0] cmd_i,
    input  logic       kbd_clk_i,
    input  logic       kbd_data_i,
    output logic       kbd_clk_oe_o,
    output logic       kbd_data_oe_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);

    localparam int CNT_MAX   = (INHIBIT_CYCLES > HOLD_CYCLES) ? INHIBIT_CYCLES : HOLD_CYCLES;
    localparam int CW        = $clog2(CNT_MAX + 1);
    localparam int ACK_SLOT  = 10;

    tx_state_t     state_q;
    logic [CW-1:0] wait_cnt_q;
    logic [3:0]    slot_q;
    logic [9:0]    shreg_q;
    logic          clk_oe_q, data_oe_q, done_q, err_q;
    logic [1:0]    lines_s;
    logic          clk_s, data_s;
    logic          fall, expired, restart, frame_active, mon_en;

    ps2tx_sync #(.WIDTH(2)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({kbd_data_i, kbd_clk_i}),
        .dout (lines_s)
    );

    assign clk_s  = lines_s[0];
    assign data_s = lines_s[1];

    ps2tx_phase_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (clk_s),
        .restart_i(restart),
        .fall_o   (fall),
        .expired_o(expired)
    );

    ps2tx_frame_monitor #(.FRAME_BITS(11)) mon_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable_i(mon_en),
        .fall_i  (fall),
        .quiet_i (expired),
        .active_o(frame_active)
    );

    // Decodes the timer restart and the monitor enable from the state.
    always_comb begin
        restart = (state_q == ST_INHIBIT) && (wait_cnt_q == CW'(INHIBIT_CYCLES - 1));
        mon_en  = (state_q == ST_IDLE) || (state_q == ST_WAIT);
    end

    // Main sequencer: request, deferral, inhibit, bit shifting, acknowledge, hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            wait_cnt_q <= '0;
            slot_q     <= '0;
            shreg_q    <= '1;
            clk_oe_q   <= 1'b0;
            data_oe_q  <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    clk_oe_q  <= 1'b0;
                    data_oe_q <= 1'b0;
                    if (send_i) begin
                        shreg_q <= {1'b1, odd_par(cmd_i), cmd_i};
                        if (frame_active) begin
                            state_q <= ST_WAIT;
                        end else begin
                            state_q    <= ST_INHIBIT;
                            clk_oe_q   <= 1'b1;
                            wait_cnt_q <= '0;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!frame_active && clk_s) begin
                        state_q    <= ST_INHIBIT;
                        clk_oe_q   <= 1'b1;
                        wait_cnt_q <= '0;
                    end
                end
                ST_INHIBIT: begin
                    if (wait_cnt_q == CW'(INHIBIT_CYCLES - 1)) begin
                        state_q   <= ST_XFER;
                        clk_oe_q  <= 1'b0;
                        data_oe_q <= 1'b1;
                        slot_q    <= '0;
                    end else begin
                        wait_cnt_q <= wait_cnt_q + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (fall) begin
                        slot_q <= slot_q + 4'd1;
                        if (slot_q == 4'(ACK_SLOT)) begin
                            data_oe_q <= 1'b0;
                            if (!data_s) begin
                                state_q    <= ST_HOLD;
                                clk_oe_q   <= 1'b1;
                                wait_cnt_q <= '0;
                                done_q     <= 1'b1;
                            end else begin
                                state_q <= ST_IDLE;
                                err_q   <= 1'b1;
                            end
                        end else begin
                            data_oe_q <= ~shreg_q[0];
                            shreg_q   <= {1'b1, shreg_q[9:1]};
                        end
                    end else if (expired) begin
                        state_q   <= ST_IDLE;
                        clk_oe_q  <= 1'b0;
                        data_oe_q <= 1'b0;
                        err_q     <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (send_i) begin
                        shreg_q    <= {1'b1, odd_par(cmd_i), cmd_i};
                        state_q    <= ST_INHIBIT;
                        wait_cnt_q <= '0;
                    end else if (wait_cnt_q == CW'(HOLD_CYCLES - 1)) begin
                        state_q  <= ST_IDLE;
                        clk_oe_q <= 1'b0;
                    end else begin
                        wait_cnt_q <= wait_cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign kbd_clk_oe_o  = clk_oe_q;
    assign kbd_data_oe_o = data_oe_q;
    assign busy_o        = (state_q == ST_WAIT) || (state_q == ST_INHIBIT) || (state_q == ST_XFER);
    assign done_o        = done_q;
    assign err_o         = err_q;

    // R1: the cycle after a reset shows everything released and quiet.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!kbd_clk_oe_o && !kbd_data_oe_o && !busy_o && !done_o && !err_o));

    // R2: releasing the clock during a transfer always comes with the start bit.
    a_r2_start_with_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(kbd_clk_oe_o) && busy_o) |-> kbd_data_oe_o);

    // R7: a completed command clamps the clock in the same cycle.
    a_r7_done_clamps: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (kbd_clk_oe_o && !err_o));

    // R9: any error leaves both lines released.
    a_r9_err_release: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!kbd_clk_oe_o && !kbd_data_oe_o));

    // R10: busy only ends together with a done or error pulse.
    a_r10_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || err_o));

    // R3: while deferring, the clock is never clamped.
    a_r3_defer_no_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !kbd_clk_oe_o);

endmodule

// File: tb/ps2_cmd_tx_tb_top.sv
`timescale 1ns/1ps
module ps2_cmd_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int INH   = 40;
    localparam int TOUT  = 120;
    localparam int HOLD  = 30;
    localparam int PHASE = 20;

    // {ack given by device, expected parity, command byte}
    localparam int NVEC = 8;
    localparam logic [9:0] VEC [NVEC] = '{
        10'h3ED, 10'h300, 10'h3FF, 10'h201,
        10'h280, 10'h33C, 10'h27F, 10'h0F4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       send = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic       dev_clk_low = 1'b0;
    logic       dev_data_low = 1'b0;
    logic       clk_oe, data_oe, busy, done, err;
    logic       clk_line, data_line;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int done_bad = 0;
    bit finished = 0;

    assign clk_line  = ~(clk_oe | dev_clk_low);
    assign data_line = ~(data_oe | dev_data_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2_cmd_tx #(
        .INHIBIT_CYCLES(INH),
        .TIMEOUT_CYCLES(TOUT),
        .HOLD_CYCLES   (HOLD)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .send_i       (send),
        .cmd_i        (cmd),
        .kbd_clk_i    (clk_line),
        .kbd_data_i   (data_line),
        .kbd_clk_oe_o (clk_oe),
        .kbd_data_oe_o(data_oe),
        .busy_o       (busy),
        .done_o       (done),
        .err_o        (err)
    );

    // Pulse counters sampled between clock edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (err)  err_cnt++;
            if (done && (!clk_oe || busy)) done_bad++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] b);
        cmd  = b;
        send = 1'b1;
        @(negedge clk);
        send = 1'b0;
    endtask

    task automatic pulse();
        dev_clk_low = 1'b1;
        cycles(PHASE);
        dev_clk_low = 1'b0;
        cycles(PHASE);
    endtask

    // Device model: waits for the start bit, generates 11 clocks, samples
    // bits in each high phase, and optionally drives the acknowledge.
    task automatic device_rx(input logic ack, output logic [9:0] bits, output bit started);
        started = 0;
        bits = '0;
        for (int i = 0; i < 500; i++) begin
            if (data_line == 1'b0 && clk_line == 1'b1) begin
                started = 1;
                break;
            end
            @(negedge clk);
        end
        if (started) begin
            cycles(10);
            for (int k = 0; k < 11; k++) begin
                dev_clk_low = 1'b1;
                cycles(PHASE);
                dev_clk_low = 1'b0;
                if (k < 10) begin
                    cycles(PHASE/2);
                    bits[k] = data_line;
                    if (k == 9 && ack) dev_data_low = 1'b1;
                    cycles(PHASE/2);
                end
            end
            dev_data_low = 1'b0;
        end
    endtask

    initial begin
        logic [9:0] bits;
        bit started;
        int n;
        int d0, e0, viol;

        cycles(3);
        // R1: reset state
        chk(!clk_oe && !data_oe && !busy && !done && !err, "R1 reset outputs",
            {clk_oe, data_oe, busy, done, err}, 0);
        rst_n = 1'b1;
        cycles(TOUT + 10);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            d0 = done_cnt; e0 = err_cnt;
            strobe(VEC[v][7:0]);
            chk(busy == 1'b1, "R10 busy after strobe", busy, 1);
            n = 0; viol = 0;
            while (clk_oe && n < 1000) begin
                if (data_oe) viol++;
                n++;
                @(negedge clk);
            end
            chk(n == INH, "R2 inhibit length", n, INH);
            chk(viol == 0 && data_oe == 1'b1, "R2 start after released inhibit", viol, 0);
            device_rx(VEC[v][9], bits, started);
            chk(started == 1, "R2 start condition seen", started, 1);
            chk(bits[7:0] == VEC[v][7:0], "R4 data bits lsb first", bits[7:0], VEC[v][7:0]);
            chk(bits[8] == VEC[v][8], "R5 odd parity", bits[8], VEC[v][8]);
            chk(bits[9] == 1'b1, "R6 stop bit released", bits[9], 1);
            if (VEC[v][9]) begin
                chk(done_cnt == d0 + 1 && err_cnt == e0, "R7 done on acknowledge", done_cnt - d0, 1);
                chk(clk_oe == 1'b1 && busy == 1'b0, "R8 clock held after ack", {clk_oe, busy}, 2);
                cycles(PHASE);
                chk(clk_oe == 1'b0, "R8 clock released after hold", clk_oe, 0);
            end else begin
                chk(err_cnt == e0 + 1 && done_cnt == d0, "R7 error on missing acknowledge", err_cnt - e0, 1);
                chk(!clk_oe && !data_oe && !busy, "R7 lines released on error", {clk_oe, data_oe, busy}, 0);
                cycles(PHASE);
            end
        end
        chk(done_bad == 0, "R7 done pulse coincides with clamp", done_bad, 0);

        // R10: strobe while busy is ignored
        cycles(TOUT);
        strobe(8'hED);
        cycles(5);
        strobe(8'h00);
        device_rx(1'b1, bits, started);
        chk(bits[7:0] == 8'hED && bits[8] == 1'b1, "R10 second strobe ignored", bits[8:0], 9'h1ED);
        cycles(HOLD + 20);

        // R3: defer while the device is sending its own frame
        cycles(TOUT + 10);
        pulse(); pulse(); pulse();
        strobe(8'h5A);
        chk(busy == 1'b1 && clk_oe == 1'b0, "R3 deferred with busy", {busy, clk_oe}, 2);
        viol = 0;
        for (int p = 4; p <= 11; p++) begin
            dev_clk_low = 1'b1;
            for (int c = 0; c < PHASE; c++) begin
                if (clk_oe) viol++;
                @(negedge clk);
            end
            dev_clk_low = 1'b0;
            if (p < 11) begin
                for (int c = 0; c < PHASE; c++) begin
                    if (clk_oe) viol++;
                    @(negedge clk);
                end
            end
        end
        chk(viol == 0, "R3 no clamp during device frame", viol, 0);
        cycles(10);
        chk(clk_oe == 1'b1, "R3 clamp after device frame", clk_oe, 1);
        device_rx(1'b1, bits, started);
        chk(bits[7:0] == 8'h5A, "R3 deferred byte sent", bits[7:0], 8'h5A);
        cycles(HOLD + 20);

        // R9: device never clocks after the start bit
        e0 = err_cnt;
        strobe(8'h12);
        cycles(INH + TOUT + 20);
        chk(err_cnt == e0 + 1, "R9 timeout error", err_cnt - e0, 1);
        chk(!clk_oe && !data_oe && !busy, "R9 lines released", {clk_oe, data_oe, busy}, 0);

        // R9: device stalls between edges
        e0 = err_cnt;
        strobe(8'h34);
        cycles(INH + 10);
        pulse(); pulse();
        cycles(TOUT + 10);
        chk(err_cnt == e0 + 1 && !data_oe, "R9 mid-frame stall error", err_cnt - e0, 1);

        // R1: reset in the middle of a transfer
        cycles(20);
        strobe(8'h00);
        cycles(INH + 10);
        pulse(); pulse();
        dev_clk_low = 1'b1;
        cycles(PHASE/2);
        chk(data_oe == 1'b1, "R4 zero bit drives line low", data_oe, 1);
        rst_n = 1'b0;
        cycles(2);
        chk(!clk_oe && !data_oe && !busy, "R1 reset mid-transfer releases", {clk_oe, data_oe, busy}, 0);
        dev_clk_low = 1'b0;
        rst_n = 1'b1;
        cycles(5);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule